// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block takes characters from the read side of a show-ahead transmit FIFO and sends each one as an asynchronous serial frame on one output line. A frame is a low start bit, then seven or eight data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Parity, parity sense, stop-bit count and character width are chosen at run time through plain inputs.

Bit timing has two sources. In internal mode a 12-bit divisor sets the bit period in system clocks. In external mode a clock from a general-purpose input pin is synchronized into the system domain. A chosen edge of that clock (rising or falling) then launches every bit, and the divisor counter is held still. The frame layout is the same in both modes. All settings are captured when a character is popped, so a frame always keeps the settings it started with.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 and `busy` is 0.
- R2: A frame on `txd` is one start bit of 0, then the data bits least significant first, then the parity bit when `parityOn` is 1, then the stop bits of value 1.
- R3: With `parityEven` at 1 the parity bit makes the count of ones in data plus parity even. With `parityEven` at 0 it makes that count odd.
- R4: With `twoStop` at 0 one stop bit ends the frame. With `twoStop` at 1 two stop bits end it.
- R5: With `eightBit` at 0 the character is `fifoData[6:0]`, seven data bits are sent, and `fifoData[7]` has no effect on the line. With `eightBit` at 1 all of `fifoData[7:0]` is sent.
- R6: In internal mode (`extClkMode` 0) the start bit appears on `txd` in the cycle after the `fifoPop` cycle. Each bit then lasts exactly `baudDiv`+1 system clocks.
- R7: In external mode (`extClkMode` 1) each bit, the start bit included, is launched by the edge of `extClkIn` that `extFallEdge` picks: 0 for rising, 1 for falling. The edge passes through a two-stage synchronizer, and `baudDiv` has no effect on the timing.
- R8: `fifoPop` is a one-cycle pulse that is high only when no frame is in progress and `fifoEmpty` is 0. `busy` is high from the start bit through the last stop bit.
- R9: Every configuration input and `fifoData` is sampled in the `fifoPop` cycle. Changes during a frame do not alter that frame.
- R10: The bit sequence of a frame is the same for the same settings whether the internal or the external clock source is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEmpty | input | 1 | Transmit FIFO has no character |
| fifoData | input | 8 | Head-of-FIFO character (show-ahead) |
| fifoPop | output | 1 | Pop strobe to the FIFO |
| parityOn | input | 1 | Append a parity bit |
| parityEven | input | 1 | 1 selects even parity, 0 selects odd parity |
| twoStop | input | 1 | 1 selects two stop bits |
| eightBit | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| extClkMode | input | 1 | 1 takes bit timing from extClkIn |
| extFallEdge | input | 1 | 1 launches bits on falling edges of extClkIn |
| extClkIn | input | 1 | External bit clock, asynchronous |
| baudDiv | input | 12 | Bit period minus one, in system clocks |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
Two events can fall in the same cycle: a bit-boundary strobe that shifts the frame, and a change on the configuration inputs. The bench provokes this by flipping parity, stop count, width, divisor and data exactly at a bit boundary in the middle of a frame. It judges the result by comparing every sampled line bit, and the cycle in which `busy` falls, against the frame built from the settings at the pop. A second overlap is a waiting character while a frame is still sending. Here the bench keeps the FIFO non-empty for the whole frame and counts any pop seen before the last stop bit ends.

// File: rtl/uft_pkg.sv
package uft_pkg;
  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;   // capture a new character and drive the start bit
    logic shift;  // advance to the next frame bit
  } uftStrobe_t;
endpackage

// File: rtl/uft_tick.sv
module uft_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extMode,
  input  logic             fallEdge,
  input  logic             extClkIn,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  input  logic             running,
  output logic             bitTick
);
  logic syncA, syncB, syncC;
  logic edgeHit;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divHold;

  // two-flop synchronizer plus one history stage for edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= extClkIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign edgeHit = fallEdge ? (syncC & ~syncB) : (syncB & ~syncC);

  // divisor counter, frozen while the external source is in use
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      divHold <= '0;
    end else if (extMode) begin
      cnt <= '0;
    end else if (restart) begin
      cnt     <= div;
      divHold <= div;
    end else if (running) begin
      cnt <= (cnt == '0) ? divHold : cnt - 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  assign bitTick = extMode ? edgeHit : (running && !restart && cnt == '0);

  // R7: internal generator stays parked in external mode
  p_gen_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    extMode |=> (cnt == '0));
endmodule

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEmpty,
  input  logic       parityOn,
  input  logic       twoStop,
  input  logic       eightBit,
  input  logic       extClkMode,
  input  logic       extFallEdge,
  input  logic       bitTick,
  output logic       fifoPop,
  output logic       busy,
  output logic       modeEff,
  output logic       edgeEff,
  output logic       restart,
  output uftStrobe_t stb
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0] bitsLeft;
  logic [CNT_W-1:0] frameLen;
  logic             modeL, edgeL;
  logic             launchOk;
  int               lenI;

  always_comb begin
    lenI = 2 + (eightBit ? DATA_W : DATA_W - 1) + (parityOn ? 1 : 0) + (twoStop ? 1 : 0);
    frameLen = CNT_W'(lenI);
  end

  // while idle the live mode decides; during a frame the captured one does
  assign modeEff  = busy ? modeL : extClkMode;
  assign edgeEff  = busy ? edgeL : extFallEdge;
  assign launchOk = extClkMode ? bitTick : 1'b1;
  assign fifoPop  = !busy && !fifoEmpty && launchOk;
  assign restart  = fifoPop;
  assign stb.load  = fifoPop;
  assign stb.shift = busy && bitTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      bitsLeft <= '0;
      modeL    <= 1'b0;
      edgeL    <= 1'b0;
    end else if (fifoPop) begin
      busy     <= 1'b1;
      bitsLeft <= frameLen;
      modeL    <= extClkMode;
      edgeL    <= extFallEdge;
    end else if (busy && bitTick) begin
      if (bitsLeft == CNT_W'(1)) busy <= 1'b0;
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  // R8: a pop always opens a frame
  p_pop_opens_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> busy);
  // R9: captured clock settings stay put inside a frame
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(modeL) && $stable(edgeL)));
  // R2: bit counter stays within one frame length while busy
  p_len_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitsLeft != '0 && bitsLeft <= CNT_W'(FRAME_W)));
endmodule

// File: rtl/uft_dpath.sv
module uft_dpath
  import uft_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  uftStrobe_t        stb,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              parityOn,
  input  logic              parityEven,
  input  logic              eightBit,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 4;

  logic [FRAME_W-1:0] frameNext;
  logic [FRAME_W-1:0] shiftReg;
  logic [DATA_W-1:0]  dataEff;
  logic               parBit;
  int                 nBits;

  // assemble start, data, parity; stop bits and fill are ones
  always_comb begin
    nBits   = eightBit ? DATA_W : DATA_W - 1;
    dataEff = eightBit ? fifoData : {1'b0, fifoData[DATA_W-2:0]};
    parBit  = parityEven ? (^dataEff) : ~(^dataEff);
    frameNext = '1;
    frameNext[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nBits) frameNext[i+1] = dataEff[i];
    end
    for (int i = 0; i < FRAME_W; i++) begin
      if (parityOn && i == nBits + 1) frameNext[i] = parBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txd      <= 1'b1;
      shiftReg <= '1;
    end else if (stb.load) begin
      txd      <= frameNext[0];
      shiftReg <= {1'b1, frameNext[FRAME_W-1:1]};
    end else if (stb.shift) begin
      txd      <= shiftReg[0];
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  // R2: the line only moves on a strobe from the sequencer
  p_line_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.shift) |=> $stable(txd));
  // R2: a load always drives the start bit low
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !txd);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoPop,
  input  logic              parityOn,
  input  logic              parityEven,
  input  logic              twoStop,
  input  logic              eightBit,
  input  logic              extClkMode,
  input  logic              extFallEdge,
  input  logic              extClkIn,
  input  logic [DIV_W-1:0]  baudDiv,
  output logic              txd,
  output logic              busy
);
  uftStrobe_t stb;
  logic bitTick, modeEff, edgeEff, restart;

  uft_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rstN(rstN), .extMode(modeEff), .fallEdge(edgeEff),
    .extClkIn(extClkIn), .div(baudDiv), .restart(restart),
    .running(busy), .bitTick(bitTick)
  );

  uft_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .parityOn(parityOn),
    .twoStop(twoStop), .eightBit(eightBit), .extClkMode(extClkMode),
    .extFallEdge(extFallEdge), .bitTick(bitTick), .fifoPop(fifoPop),
    .busy(busy), .modeEff(modeEff), .edgeEff(edgeEff), .restart(restart),
    .stb(stb)
  );

  uft_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .fifoData(fifoData),
    .parityOn(parityOn), .parityEven(parityEven), .eightBit(eightBit),
    .txd(txd)
  );

  // R1: idle line is high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txd);
  // R6: a frame opens with the line low
  p_frame_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txd);
  // R8: no pop while a frame is running
  p_no_pop_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !fifoPop);
endmodule

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEmpty = 1'b1;
  logic [7:0] fifoData = '0;
  logic fifoPop;
  logic parityOn = 0, parityEven = 0, twoStop = 0, eightBit = 1;
  logic extClkMode = 0, extFallEdge = 0, extClkIn = 0;
  logic [11:0] baudDiv = '0;
  logic txd, busy;
  int nChecks = 0;
  int nFails = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_frame_tx u0 (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .fifoData(fifoData),
    .fifoPop(fifoPop), .parityOn(parityOn), .parityEven(parityEven),
    .twoStop(twoStop), .eightBit(eightBit), .extClkMode(extClkMode),
    .extFallEdge(extFallEdge), .extClkIn(extClkIn), .baudDiv(baudDiv),
    .txd(txd), .busy(busy)
  );

  // external bit clock: period 16 system clocks, changes on falling clk
  initial begin
    forever begin
      repeat (8) @(negedge clk);
      extClkIn = ~extClkIn;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected frame built from the requirements, bit 0 first on the line
  function automatic void buildExp(input logic [7:0] d, input bit pOn, input bit pEven,
                                   input bit two, input bit eight,
                                   output logic [11:0] v, output int n);
    int nd, ones;
    v = '1;
    v[0] = 1'b0;
    nd = eight ? 8 : 7;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      v[1+i] = d[i];
      if (d[i]) ones++;
    end
    if (pOn) v[1+nd] = pEven ? ((ones % 2) == 1) : ((ones % 2) == 0);
    n = 1 + nd + (pOn ? 1 : 0) + 1 + (two ? 1 : 0);
  endfunction

  task automatic setCfg(logic [7:0] d, bit pOn, bit pEven, bit two, bit eight);
    fifoData = d; parityOn = pOn; parityEven = pEven; twoStop = two; eightBit = eight;
  endtask

  task automatic runInt(string req, logic [7:0] d, bit pOn, bit pEven, bit two,
                        bit eight, int div, bit midChange, bit keepFull);
    logic [11:0] exp, got;
    int n, per, popsSeen;
    buildExp(d, pOn, pEven, two, eight, exp, n);
    per = div + 1;
    got = '1;
    popsSeen = 0;
    @(negedge clk);
    setCfg(d, pOn, pEven, two, eight);
    extClkMode = 0;
    baudDiv = 12'(div);
    fifoEmpty = 0;
    #1;
    while (!fifoPop) begin @(negedge clk); #1; end
    @(posedge clk);
    for (int t = 0; t <= n * per; t++) begin
      @(negedge clk);
      if (t == 0 && !keepFull) fifoEmpty = 1;
      if (keepFull && t == n * per - 1) fifoEmpty = 1;
      if (midChange && t == 2 * per) begin  // R9 stimulus on a bit boundary
        parityOn = ~parityOn; parityEven = ~parityEven; twoStop = ~twoStop;
        eightBit = ~eightBit; baudDiv = 12'd9; fifoData = ~fifoData;
      end
      #1;
      if (keepFull && t < n * per - 1 && fifoPop) popsSeen++;
      if ((t % per) == div / 2 && (t / per) < n) got[t / per] = txd;
      if (t == n * per - 1) check(busy == 1'b1, {req, " busy through last stop"}, busy, 1);
      if (t == n * per) check(busy == 1'b0 && txd == 1'b1, {req, " frame end/idle"}, {busy, txd}, 2'b01);
    end
    check(got == exp, {req, " frame bits"}, got, exp);
    if (keepFull) check(popsSeen == 0, "R8 pop while busy", popsSeen, 0);
  endtask

  task automatic waitExtEdge(bit fall);
    if (fall) @(negedge extClkIn); else @(posedge extClkIn);
  endtask

  task automatic runExt(string req, logic [7:0] d, bit pOn, bit pEven, bit two,
                        bit eight, bit fall);
    logic [11:0] exp, got;
    int n;
    buildExp(d, pOn, pEven, two, eight, exp, n);
    got = '1;
    @(negedge clk);
    setCfg(d, pOn, pEven, two, eight);
    extClkMode = 1;
    extFallEdge = fall;
    baudDiv = 12'hFFF;  // must have no effect in this mode
    fifoEmpty = 0;
    #1;
    while (!fifoPop) begin @(negedge clk); #1; end
    // R7: the launch follows the chosen edge, so the level is still the post-edge one
    check(extClkIn == !fall, "R7 launch edge", extClkIn, !fall);
    @(posedge clk);
    @(negedge clk);
    fifoEmpty = 1;
    @(negedge clk);
    got[0] = txd;
    for (int k = 1; k < n; k++) begin
      waitExtEdge(fall);
      repeat (6) @(negedge clk);
      got[k] = txd;
      if (k == n - 1) check(busy == 1'b1, {req, " busy on last stop"}, busy, 1);
    end
    waitExtEdge(fall);
    repeat (6) @(negedge clk);
    check(busy == 1'b0 && txd == 1'b1, {req, " frame end/idle"}, {busy, txd}, 2'b01);
    check(got == exp, {req, " frame bits"}, got, exp);
    @(negedge clk);
    extClkMode = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0, "R1 in reset", {txd, busy}, 2'b10);
    rstN = 1;
    repeat (2) @(negedge clk);
    #1;
    check(txd == 1'b1 && busy == 1'b0 && fifoPop == 1'b0, "R1 after reset",
          {txd, busy, fifoPop}, 3'b100);
  endtask

  task automatic t_idle;
    int bad = 0;
    fifoEmpty = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (fifoPop || busy || !txd) bad++;
    end
    check(bad == 0, "R8 no pop when empty / R1 idle", bad, 0);
  endtask

  initial begin
    t_reset();
    runInt("R2 R6 8N1", 8'hA5, 0, 0, 0, 1, 3, 0, 0);
    runInt("R3 R4 R5 7E2", 8'hC3, 1, 1, 1, 0, 2, 0, 0);
    runInt("R3 R6 8O1 div0", 8'h00, 1, 0, 0, 1, 0, 0, 0);
    runInt("R3 R4 8E2", 8'h0F, 1, 1, 1, 1, 1, 0, 0);
    runInt("R9 midframe change", 8'h3C, 0, 0, 0, 1, 4, 1, 0);
    runInt("R8 waiting char", 8'h81, 1, 0, 0, 1, 2, 0, 1);
    t_idle();
    runExt("R7 R10 rising 8E2", 8'h5A, 1, 1, 1, 1, 0);
    runExt("R7 R5 falling 7O1", 8'h96, 1, 0, 0, 0, 1);
    if (!doneFlag) begin
      doneFlag = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule